// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block holds the two threshold offsets that a FIFO's flag logic compares against: one for the almost-empty flag and one for the almost-full flag. It supplies their power-on defaults and lets them be rewritten later, either one bit at a time through a serial input or a whole word at a time from the parallel data bus. The current values can be read back onto a readback bus with either loading method. The FIFO storage and the flag comparators sit outside this block. This block only keeps the two offsets and drives them to the flag logic.

The value of the load control during master reset sets up the block for the time until the next master reset. Held high, it selects the larger default and serial programming. Held low, it selects the smaller default and parallel programming. While the load control is high, all enables apply to the offset registers. The FIFO write and read strobes passed downstream are gated off during that time, so offset accesses never move the FIFO's data pointers. Partial reset restarts the access sequence but keeps the programmed offsets and the chosen method.

Top module: `fol_loader`

## Requirements
- R1: In a cycle with `mrst` high, the block latches `ld`. With `ld`=1, both offsets become 1023 and the method becomes serial. With `ld`=0, both offsets become 127 and the method becomes parallel. The new values appear on `ae_off` and `af_off` in the next cycle.
- R2: Master reset points the access sequence at the almost-empty register and clears the serial bit position. The first access after it goes to almost-empty.
- R3: In serial method, each cycle with `ld` and `sen` high writes `sdi` into the selected offset at the current bit position. Bits go least significant first. After OFF_W such bits (14 by default), the bit position returns to 0 and the sequence advances.
- R4: In parallel method, a cycle with `ld` and `wen` high writes `din[OFF_W-1:0]` into the selected offset, and the sequence advances. The new value shows on the offset output in the next cycle.
- R5: In serial method, `wen` cannot change an offset. In parallel method, `sen` and `sdi` cannot change an offset.
- R6: A cycle with `ld` and `ren` high and no offset write gives a result in the next cycle. `rb_vld` is 1 and `rb_data` holds the selected offset, zero-extended to DATA_W. The sequence then advances. In every other cycle, `rb_vld` and `rb_data` are 0. Readback works with both methods.
- R7: Writes and readbacks share one sequence: almost-empty, then almost-full, then back to almost-empty.
- R8: In a cycle with `prst` high, the sequence returns to almost-empty, the bit position is cleared, and `rb_vld` becomes 0. The offsets and the method are left unchanged, and no write or readback happens in that cycle.
- R9: `fifo_wr` equals `wen & ~ld` and `fifo_rd` equals `ren & ~ld`, within the same cycle.
- R10: When an offset write (parallel word or serial bit) and a readback request fall in the same cycle, the write is done. The readback is dropped and `rb_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld | input | 1 | Load control: selects defaults and method at master reset, and routes enables to the offsets otherwise |
| sen | input | 1 | Serial bit enable |
| sdi | input | 1 | Serial data bit |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| din | input | DATA_W | Parallel data bus |
| fifo_wr | output | 1 | Gated FIFO write strobe |
| fifo_rd | output | 1 | Gated FIFO read strobe |
| ae_off | output | OFF_W | Almost-empty offset to flag logic |
| af_off | output | OFF_W | Almost-full offset to flag logic |
| rb_data | output | DATA_W | Readback word |
| rb_vld | output | 1 | Readback word valid |

## Verification
The FIFO strobes are combinational, so they are due in the same cycle as the enables that drive them. Offset updates from either reset, a parallel word or a serial bit are due one edge after the accepting cycle. A readback word appears on the edge after the request. The bench drives inputs on the falling edge and compares at the next falling edge against a behavioural model. Before applying new inputs, it checks the strobes against the inputs still applied and checks the registered outputs against the model's state after the rising edge that has just passed.

// File: rtl/fol_pkg.sv
package fol_pkg;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } sel_e;

    typedef enum logic {
        METH_PAR = 1'b0,
        METH_SER = 1'b1
    } meth_e;

    // one cycle's decoded offset access
    typedef struct packed {
        logic wr_word;   // parallel word write
        logic wr_bit;    // serial bit write
        logic rd;        // readback request accepted
    } acc_t;

    function automatic sel_e sel_next(sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    function automatic meth_e meth_from_ld(logic ld);
        return ld ? METH_SER : METH_PAR;
    endfunction

endpackage

// File: rtl/fol_mode.sv
module fol_mode
    import fol_pkg::*;
(
    input  logic  clk,
    input  logic  mrst,
    input  logic  prst,
    input  logic  ld,
    input  logic  sen,
    input  logic  wen,
    input  logic  ren,
    output meth_e meth,
    output acc_t  acc
);
    meth_e meth_q;
    logic  live;

    always_ff @(posedge clk) begin
        if (mrst)
            meth_q <= meth_from_ld(ld);
    end

    assign live = ld & ~mrst & ~prst;

    always_comb begin
        acc.wr_word = live & (meth_q == METH_PAR) & wen;
        acc.wr_bit  = live & (meth_q == METH_SER) & sen;
        acc.rd      = live & ren & ~(acc.wr_word | acc.wr_bit);
    end

    assign meth = meth_q;
endmodule

// File: rtl/fol_seq.sv
module fol_seq
    import fol_pkg::*;
#(
    parameter int OFF_W = 14,
    localparam int CNT_W = (OFF_W > 1) ? $clog2(OFF_W) : 1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  acc_t             acc,
    output sel_e             sel,
    output logic [CNT_W-1:0] bit_pos
);
    sel_e             sel_q;
    logic [CNT_W-1:0] pos_q;
    logic             last_bit;

    assign last_bit = (pos_q == CNT_W'(OFF_W - 1));

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            sel_q <= SEL_AE;
            pos_q <= '0;
        end else if (acc.wr_bit) begin
            if (last_bit) begin
                pos_q <= '0;
                sel_q <= sel_next(sel_q);
            end else begin
                pos_q <= pos_q + CNT_W'(1);
            end
        end else if (acc.wr_word || acc.rd) begin
            sel_q <= sel_next(sel_q);
        end
    end

    assign sel     = sel_q;
    assign bit_pos = pos_q;
endmodule

// File: rtl/fol_bank.sv
module fol_bank
    import fol_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int OFF_W     = 14,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023,
    localparam int CNT_W    = (OFF_W > 1) ? $clog2(OFF_W) : 1,
    localparam int N_REG    = 2
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld,
    input  logic              sdi,
    input  logic [DATA_W-1:0] din,
    input  acc_t              acc,
    input  sel_e              sel,
    input  logic [CNT_W-1:0]  bit_pos,
    output logic [OFF_W-1:0]  ae_off,
    output logic [OFF_W-1:0]  af_off,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_vld
);
    logic [OFF_W-1:0] off_q [N_REG];
    logic             unused_din_hi;

    assign unused_din_hi = ^din[DATA_W-1:OFF_W];

    for (genvar g = 0; g < N_REG; g++) begin : g_off
        logic hit;
        assign hit = (sel == sel_e'(g));
        always_ff @(posedge clk) begin
            if (mrst)
                off_q[g] <= ld ? OFF_W'(DEF_LARGE) : OFF_W'(DEF_SMALL);
            else if (acc.wr_word && hit)
                off_q[g] <= din[OFF_W-1:0];
            else if (acc.wr_bit && hit)
                off_q[g][bit_pos] <= sdi;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst || prst || !acc.rd) begin
            rb_vld  <= 1'b0;
            rb_data <= '0;
        end else begin
            rb_vld  <= 1'b1;
            rb_data <= DATA_W'((sel == SEL_AE) ? off_q[0] : off_q[1]);
        end
    end

    assign ae_off = off_q[0];
    assign af_off = off_q[1];
endmodule

// File: rtl/fol_loader.sv
module fol_loader
    import fol_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int OFF_W     = 14,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023,
    localparam int CNT_W    = (OFF_W > 1) ? $clog2(OFF_W) : 1
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld,
    input  logic              sen,
    input  logic              sdi,
    input  logic              wen,
    input  logic              ren,
    input  logic [DATA_W-1:0] din,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic [OFF_W-1:0]  ae_off,
    output logic [OFF_W-1:0]  af_off,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_vld
);
    meth_e            meth;
    acc_t             acc;
    sel_e             sel;
    logic [CNT_W-1:0] bit_pos;
    logic             unused_meth;

    assign unused_meth = (meth == METH_SER);

    // FIFO strobes are blocked while the offsets own the enables
    assign fifo_wr = wen & ~ld;
    assign fifo_rd = ren & ~ld;

    fol_mode u_mode (
        .clk  (clk),
        .mrst (mrst),
        .prst (prst),
        .ld   (ld),
        .sen  (sen),
        .wen  (wen),
        .ren  (ren),
        .meth (meth),
        .acc  (acc)
    );

    fol_seq #(.OFF_W(OFF_W)) u_seq (
        .clk     (clk),
        .mrst    (mrst),
        .prst    (prst),
        .acc     (acc),
        .sel     (sel),
        .bit_pos (bit_pos)
    );

    fol_bank #(
        .DATA_W    (DATA_W),
        .OFF_W     (OFF_W),
        .DEF_SMALL (DEF_SMALL),
        .DEF_LARGE (DEF_LARGE)
    ) u_bank (
        .clk     (clk),
        .mrst    (mrst),
        .prst    (prst),
        .ld      (ld),
        .sdi     (sdi),
        .din     (din),
        .acc     (acc),
        .sel     (sel),
        .bit_pos (bit_pos),
        .ae_off  (ae_off),
        .af_off  (af_off),
        .rb_data (rb_data),
        .rb_vld  (rb_vld)
    );
endmodule

// File: rtl/fol_loader_chk.sv
module fol_loader_chk #(
    parameter int OFF_W     = 14,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023
) (
    input logic             clk,
    input logic             mrst,
    input logic             prst,
    input logic             ld,
    input logic             wen,
    input logic             ren,
    input logic             fifo_wr,
    input logic             fifo_rd,
    input logic [OFF_W-1:0] ae_off,
    input logic [OFF_W-1:0] af_off,
    input logic             rb_vld
);
    // R9: no FIFO strobe while the load control is high
    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (mrst)
        ld |-> (!fifo_wr && !fifo_rd));

    // R9: strobe passes when load control is low
    p_strobe_pass_r9: assert property (@(posedge clk) disable iff (mrst)
        (!ld && wen) |-> fifo_wr);

    // R1: both offsets take the same default after master reset
    p_mrst_default_r1: assert property (@(posedge clk)
        (mrst && ld) |=> (ae_off == OFF_W'(DEF_LARGE) && af_off == OFF_W'(DEF_LARGE)));

    p_mrst_small_r1: assert property (@(posedge clk)
        (mrst && !ld) |=> (ae_off == OFF_W'(DEF_SMALL) && af_off == OFF_W'(DEF_SMALL)));

    // R8: partial reset keeps offsets and drops readback
    p_prst_keep_r8: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(ae_off) && $stable(af_off) && !rb_vld));

    // R6: readback only follows a request
    p_rb_cause_r6: assert property (@(posedge clk) disable iff (mrst)
        rb_vld |-> $past(ld && ren));

    // R7: one offset access per cycle at most
    p_single_target_r7: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> !((ae_off != $past(ae_off)) && (af_off != $past(af_off))));
endmodule

bind fol_loader fol_loader_chk #(
    .OFF_W     (OFF_W),
    .DEF_SMALL (DEF_SMALL),
    .DEF_LARGE (DEF_LARGE)
) u_chk (
    .clk     (clk),
    .mrst    (mrst),
    .prst    (prst),
    .ld      (ld),
    .wen     (wen),
    .ren     (ren),
    .fifo_wr (fifo_wr),
    .fifo_rd (fifo_rd),
    .ae_off  (ae_off),
    .af_off  (af_off),
    .rb_vld  (rb_vld)
);

// File: tb/fol_loader_tb.sv
`timescale 1ns/1ps
module fol_loader_tb;
    localparam int DATA_W = 18;
    localparam int OFF_W  = 14;

    logic              clk = 1'b0;
    logic              mrst = 1'b1, prst = 1'b0, ld = 1'b0, sen = 1'b0, sdi = 1'b0;
    logic              wen = 1'b0, ren = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              fifo_wr, fifo_rd, rb_vld;
    logic [OFF_W-1:0]  ae_off, af_off;
    logic [DATA_W-1:0] rb_data;

    always #2 clk = ~clk;

    fol_loader #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .mrst(mrst), .prst(prst), .ld(ld), .sen(sen), .sdi(sdi),
        .wen(wen), .ren(ren), .din(din), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
        .ae_off(ae_off), .af_off(af_off), .rb_data(rb_data), .rb_vld(rb_vld)
    );

    // behavioural reference
    int     m_off [2];
    int     m_ptr = 0, m_cnt = 0, m_rbd = 0;
    bit     m_ser = 0, m_rbv = 0, armed = 0;
    int     nchk = 0, nfail = 0;
    string  tag = "R1";

    always @(posedge clk) begin
        if (mrst) begin
            m_ser = ld;
            m_off[0] = ld ? 1023 : 127;
            m_off[1] = m_off[0];
            m_ptr = 0; m_cnt = 0; m_rbv = 0; m_rbd = 0;
            armed = 1;
        end else if (prst) begin
            m_ptr = 0; m_cnt = 0; m_rbv = 0; m_rbd = 0;
        end else if (ld && (m_ser ? sen : wen)) begin
            if (m_ser) begin
                if (sdi) m_off[m_ptr] = m_off[m_ptr] | (1 << m_cnt);
                else     m_off[m_ptr] = m_off[m_ptr] & ~(1 << m_cnt);
                m_cnt++;
                if (m_cnt == OFF_W) begin m_cnt = 0; m_ptr ^= 1; end
            end else begin
                m_off[m_ptr] = int'(din) & ((1 << OFF_W) - 1);
                m_ptr ^= 1;
            end
            m_rbv = 0; m_rbd = 0;
        end else if (ld && ren) begin
            m_rbd = m_off[m_ptr]; m_rbv = 1; m_ptr ^= 1;
        end else begin
            m_rbv = 0; m_rbd = 0;
        end
    end

    task automatic chk(string r, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!armed) return;
        chk(tag, "ae_off", int'(ae_off), m_off[0]);
        chk(tag, "af_off", int'(af_off), m_off[1]);
        chk("R6", "rb_vld", int'(rb_vld), int'(m_rbv));
        chk("R6", "rb_data", int'(rb_data), m_rbd);
        chk("R9", "fifo_wr", int'(fifo_wr), int'(wen & ~ld));
        chk("R9", "fifo_rd", int'(fifo_rd), int'(ren & ~ld));
    endtask

    task automatic cyc(input bit m, p, l, s, sd, w, r, input int d);
        @(negedge clk);
        compare();
        mrst = m; prst = p; ld = l; sen = s; sdi = sd; wen = w; ren = r;
        din = DATA_W'(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic ser_word(int v);
        for (int i = 0; i < OFF_W; i++) cyc(0, 0, 1, 1, v[i], 0, 0, 0);
    endtask

    task automatic rd_one();
        cyc(0, 0, 1, 0, 0, 0, 1, 0);
    endtask

    bit done = 0;

    initial begin
        // R1: master reset with load low -> small defaults, parallel
        tag = "R1";
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        idle(2);
        // R4: parallel word writes, upper bus bits dropped
        tag = "R4";
        cyc(0, 0, 1, 0, 0, 1, 0, 'h3_1234);
        cyc(0, 0, 1, 0, 0, 1, 0, 'h0_0555);
        idle(1);
        // R7: readback order wraps to almost-empty
        tag = "R7";
        rd_one(); rd_one(); rd_one(); idle(1);
        // R5: serial strobes ignored in parallel method
        tag = "R5";
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, 1, 1, 0, 0, 0);
        idle(1);
        // R9: normal FIFO traffic passes with load low
        tag = "R9";
        cyc(0, 0, 0, 0, 0, 1, 0, 7);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 1, 9);
        idle(1);
        // R8: partial reset restarts sequence, keeps offsets
        tag = "R8";
        cyc(0, 0, 1, 0, 0, 1, 0, 100);
        cyc(0, 1, 1, 0, 0, 1, 1, 200);
        cyc(0, 0, 1, 0, 0, 1, 0, 300);
        rd_one(); rd_one(); idle(1);
        // R10: write beats readback in the same cycle
        tag = "R10";
        cyc(0, 0, 1, 0, 0, 1, 1, 44);
        rd_one(); idle(1);
        // R1: master reset with load high -> large defaults, serial
        tag = "R1";
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        idle(2);
        // R5: parallel writes ignored in serial method
        tag = "R5";
        cyc(0, 0, 1, 0, 0, 1, 0, 'h2AAA);
        cyc(0, 0, 1, 0, 0, 1, 0, 'h1555);
        idle(1);
        // R3: serial words, LSB first
        tag = "R3";
        ser_word('h2A5C);
        ser_word('h00F3);
        rd_one(); rd_one(); idle(1);
        // R8: partial reset mid-serial
        tag = "R8";
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0, 0);
        ser_word('h1001);
        rd_one(); idle(1);
        // R10: serial bit beats readback
        tag = "R10";
        cyc(0, 0, 1, 1, 1, 0, 1, 0);
        idle(1);
        // R2: master reset mid-sequence returns to almost-empty
        tag = "R2";
        cyc(0, 0, 1, 1, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 1, 0, 321);
        rd_one(); idle(1);
        // R6: mixed random traffic
        tag = "R6";
        for (int i = 0; i < 2000; i++) begin
            int rr = $urandom_range(0, 99);
            cyc(rr == 0, rr == 1, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, int'($urandom_range(0, 262143)));
        end
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule